// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches the two I2C bus lines, sampled on the system clock, and decides after every START condition whether the first byte on the bus addresses this device. The byte is compared with a programmable 7-bit own address and with the general call address. A match is acknowledged on the ninth clock by pulling SDA low, and a sticky interrupt flag is raised together with a code that tells what kind of match it was. A slave data phase that follows the address is handled elsewhere.

Recognition keeps running while the local master drives the bus. An input tells the block whether the local master still owns the current address byte. If that input falls before the byte ends, because arbitration was lost, the block acknowledges and reports its own address in that same transfer. A bus-busy output, set by START and cleared by STOP, lets a master request wait for a free bus so that a slave transfer already under way is not cut off.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: A byte after START whose upper seven bits equal `own_addr` is acknowledged. `match_kind` becomes 1 when bit 0 is 0 (write) and 2 when bit 0 is 1 (read).
- R2: The byte 8'h00 (general call) is acknowledged and gives `match_kind` 3. The byte 8'h01 is neither acknowledged nor reported.
- R3: Any other address byte leaves `sda_pull` low and `irq` low.
- R4: While `ack_en` is 0, no address is acknowledged and `irq` stays low.
- R5: Address bits are taken MSB first on SCL rising edges. On a match, `sda_pull` is high from the falling edge of the 8th clock to the falling edge of the 9th clock, and is high at no other time.
- R6: If `mst_own` is 1 at the 8th rising edge, the byte is not acknowledged. If `mst_own` falls at any point before that edge (arbitration lost), the byte is recognized as in R1 and R2.
- R7: A START or a STOP in the middle of a byte discards the bits collected so far. After a repeated START the next byte is judged from its own bits only.
- R8: `bus_busy` rises after a START and falls after a STOP.
- R9: `irq` and `match_kind` are set on an acknowledged match and hold until `irq_clr` clears them to 0. `match_kind` is 0 while `irq` is low.
- R10: After reset, `sda_pull`, `irq`, `match_kind` and `bus_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| own_addr | input | 7 | Programmed own slave address |
| ack_en | input | 1 | Acknowledge enable |
| mst_own | input | 1 | Local master still owns the current byte |
| irq_clr | input | 1 | Clears the interrupt flag and the match code |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| irq | output | 1 | Sticky match interrupt |
| match_kind | output | 2 | 0 none, 1 own write, 2 own read, 3 general call |
| bus_busy | output | 1 | Bus is between START and STOP |

## Verification
A shift register that slips by one bit, or a bit counter that is off by one, shows up as wrong acknowledges in the sweep over all 256 address bytes. The error appears within the ninth clock of the affected byte. A partial byte that survives a START or a STOP makes the next address be judged wrongly, and this is seen at that byte's acknowledge. An ACK phase that is stuck, or that ends late, holds SDA low through the following START or STOP. The STOP is then not detected, so `bus_busy` stays high when it is checked after the STOP. Wrong match decoding appears in `match_kind` before the interrupt is cleared.

// File: rtl/i2c_arx_pkg.sv
package i2c_arx_pkg;
  localparam int ADDR_BITS = 7;
  localparam int BYTE_BITS = ADDR_BITS + 1;

  typedef enum logic [1:0] {
    MK_NONE   = 2'd0,
    MK_OWN_WR = 2'd1,
    MK_OWN_RD = 2'd2,
    MK_GCALL  = 2'd3
  } match_kind_t;

  // General call: all address bits zero and direction bit zero
  function automatic logic is_gcall(input logic [BYTE_BITS-1:0] b);
    return b == '0;
  endfunction

  function automatic logic is_own(input logic [BYTE_BITS-1:0] b,
                                  input logic [ADDR_BITS-1:0] own);
    return b[BYTE_BITS-1:1] == own;
  endfunction

  // The general call takes priority over a match of the own address
  function automatic match_kind_t classify(input logic [BYTE_BITS-1:0] b,
                                           input logic [ADDR_BITS-1:0] own);
    if (is_gcall(b))     return MK_GCALL;
    if (is_own(b, own))  return b[0] ? MK_OWN_RD : MK_OWN_WR;
    return MK_NONE;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // An SDA edge while SCL stays high is a bus condition
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_shift.sv
module i2c_addr_shift
  import i2c_arx_pkg::*;
#(
  parameter int CNT_W = $clog2(BYTE_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic                 scl_rise,
  input  logic                 sda_s,
  output logic                 byte_done,
  output logic [BYTE_BITS-1:0] byte_val
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic [BYTE_BITS-2:0] shreg;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      armed   <= 1'b0;
    end else if (start_ev) begin
      shreg   <= '0;
      bit_cnt <= '0;
      armed   <= 1'b1;
    end else if (stop_ev) begin
      shreg   <= '0;
      bit_cnt <= '0;
      armed   <= 1'b0;
    end else if (armed && scl_rise) begin
      shreg <= {shreg[BYTE_BITS-3:0], sda_s};
      if (bit_cnt == LAST_BIT) begin
        bit_cnt <= '0;
        armed   <= 1'b0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign byte_done = armed && scl_rise && (bit_cnt == LAST_BIT);
  assign byte_val  = {shreg, sda_s};

  // R7
  // discard_chk
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> (bit_cnt == '0));
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
  import i2c_arx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 ack_en,
  input  logic                 mst_own,
  input  logic                 irq_clr,
  output logic                 sda_pull,
  output logic                 irq,
  output logic [1:0]           match_kind,
  output logic                 bus_busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_FALL, ST_ACK} ack_state_t;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_done;
  logic [BYTE_BITS-1:0] byte_val;
  match_kind_t byte_kind, pend_kind;
  logic        take_byte;
  ack_state_t  state;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_addr_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .sda_s(sda_s),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  assign byte_kind = classify(byte_val, own_addr);
  // The byte is taken only if enabled, matched and the local master has given it up
  assign take_byte = ack_en && !mst_own && (byte_kind != MK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_kind <= MK_NONE;
      sda_pull  <= 1'b0;
    end else if (start_ev || stop_ev) begin
      state     <= ST_IDLE;
      pend_kind <= MK_NONE;
      sda_pull  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (byte_done && take_byte) begin
          state     <= ST_WAIT_FALL;
          pend_kind <= byte_kind;
        end
        ST_WAIT_FALL: if (scl_fall) begin
          state    <= ST_ACK;
          sda_pull <= 1'b1;
        end
        ST_ACK: if (scl_fall) begin
          state     <= ST_IDLE;
          sda_pull  <= 1'b0;
          pend_kind <= MK_NONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic ack_begin;
  assign ack_begin = (state == ST_WAIT_FALL) && scl_fall && !start_ev && !stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      match_kind <= MK_NONE;
    end else if (ack_begin) begin
      irq        <= 1'b1;
      match_kind <= pend_kind;
    end else if (irq_clr) begin
      irq        <= 1'b0;
      match_kind <= MK_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_busy <= 1'b0;
    else if (start_ev) bus_busy <= 1'b1;
    else if (stop_ev)  bus_busy <= 1'b0;
  end

  // R8
  // busy_set_chk
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> bus_busy);
  // R8
  // busy_clr_chk
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !bus_busy);
  // R9
  // irq_kind_chk
  irq_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == (match_kind != 2'd0)));
  // R5
  // pull_on_fall_chk
  pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  // R4
  // pull_needs_en_chk
  pull_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ack_en && state == ST_IDLE) |=> (state == ST_IDLE));
endmodule

// File: tb/test_i2c_addr_recognizer.sv
module test_i2c_addr_recognizer;
  localparam int H = 8;
  localparam logic [6:0] OWN_A = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic [6:0] own_addr = OWN_A;
  logic ack_en = 1'b1, mst_own = 1'b0, irq_clr = 1'b0;
  logic sda_pull, irq, bus_busy;
  logic [1:0] match_kind;
  logic sda_line;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;

  i2c_addr_recognizer i_i2c_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .own_addr(own_addr), .ack_en(ack_en), .mst_own(mst_own), .irq_clr(irq_clr),
    .sda_pull(sda_pull), .irq(irq), .match_kind(match_kind), .bus_busy(bus_busy)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; wt(H); scl = 1'b1; wt(H); sda_drv = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; wt(H); scl = 1'b1; wt(H); sda_drv = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(H);
  endtask

  // Returns 1 when the line was held low during the ninth clock
  task automatic ack_bit(output logic acked);
    sda_drv = 1'b1; wt(H); scl = 1'b1; wt(H/2);
    acked = ~sda_line;
    wt(H/2); scl = 1'b0; wt(H);
  endtask

  task automatic clear_irq;
    irq_clr = 1'b1; wt(1); irq_clr = 1'b0; wt(1);
  endtask

  function automatic int exp_kind(input logic [7:0] b, input logic [6:0] own);
    if (b == 8'h00) return 3;
    if (b[7:1] == own) return b[0] ? 2 : 1;
    return 0;
  endfunction

  // Full address transfer with optional master ownership released before bit drop_at
  task automatic addr_xfer(input logic [7:0] b, input int drop_at, output logic acked);
    bus_start;
    for (int i = 7; i >= 0; i--) begin
      if ((7 - i) == drop_at) mst_own = 1'b0;
      send_bit(b[i]);
    end
    ack_bit(acked);
    bus_stop;
  endtask

  initial begin
    logic a;
    wt(4);
    chk("R10 sda_pull", sda_pull, 0);
    chk("R10 irq", irq, 0);
    chk("R10 match_kind", match_kind, 0);
    chk("R10 bus_busy", bus_busy, 0);
    rst_n = 1'b1; wt(4);

    // Sweep all address bytes (R1 R2 R3 R5)
    for (int v = 0; v < 256; v++) begin
      int ek;
      ek = exp_kind(8'(v), OWN_A);
      addr_xfer(8'(v), -1, a);
      chk("R5 ack", a, ek != 0);
      chk(ek == 3 ? "R2 kind" : (ek != 0 ? "R1 kind" : "R3 kind"), match_kind, ek);
      chk("R9 irq", irq, ek != 0);
      chk("R8 idle after stop", bus_busy, 0);
      clear_irq;
      chk("R9 cleared", match_kind, 0);
    end

    // Second own address
    own_addr = 7'h7F;
    addr_xfer(8'hFF, -1, a);
    chk("R1 read other addr", match_kind, 2);
    clear_irq;
    own_addr = OWN_A;

    // R4 acknowledge disabled
    ack_en = 1'b0;
    addr_xfer({OWN_A, 1'b0}, -1, a);
    chk("R4 no ack own", a, 0);
    chk("R4 no irq own", irq, 0);
    addr_xfer(8'h00, -1, a);
    chk("R4 no ack gcall", a, 0);
    chk("R4 no irq gcall", irq, 0);
    ack_en = 1'b1;

    // R6 master keeps the byte / loses it mid-byte
    mst_own = 1'b1;
    addr_xfer({OWN_A, 1'b1}, -1, a);
    chk("R6 owned no ack", a, 0);
    chk("R6 owned no irq", irq, 0);
    mst_own = 1'b1;
    addr_xfer({OWN_A, 1'b1}, 4, a);
    chk("R6 lost ack", a, 1);
    chk("R6 lost kind", match_kind, 2);
    clear_irq;
    mst_own = 1'b0;

    // R7 STOP mid-byte
    bus_start;
    chk("R8 busy after start", bus_busy, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop;
    chk("R7 stop idle", bus_busy, 0);
    chk("R7 stop no irq", irq, 0);
    chk("R7 stop no pull", sda_pull, 0);

    // R7 repeated START mid-byte, then own write
    bus_start;
    for (int k = 0; k < 5; k++) send_bit(1'b0);
    bus_start;
    for (int i = 7; i >= 0; i--) send_bit(OWN_A_W(i));
    ack_bit(a);
    bus_stop;
    chk("R7 restart ack", a, 1);
    chk("R7 restart kind", match_kind, 1);
    clear_irq;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic OWN_A_W(input int i);
    logic [7:0] b;
    b = {OWN_A, 1'b0};
    return b[i];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule